// File: doc/BRIEF.md
# Two-Step Register Write-Enable Controller

This block sits between a byte-level serial bus front end and a small register file. The front end reports bus events as single-cycle pulses: a start condition, a stop condition, a received byte, and a framing error such as a wrong bit count. The controller matches the device address and follows each write transaction through its word address and data bytes. When a transaction ends cleanly, it decides whether the staged bytes may be written into the protected register areas. If they may, it presents them on a commit port, together with the start address and the byte count, for the storage cells to take.

Protected writes need a two-stage unlock, done through a status register that holds two volatile latches. The first latch is the write-enable latch. The second is the register-write latch, and it can only be set while the first is already set. A committed protected write clears the second latch, so each change needs its own unlock. An aborted write leaves the second latch set. Writes to the non-volatile control area start a slow programming cycle. A busy flag stands in for that cycle, and every write that ends while busy is high is ignored.

Top module: `regwr_guard`

## Requirements
- R1: A transaction whose first byte is 8'hDE is a write and one whose first byte is 8'hDF is a read. Both device bytes, and every byte that follows in a write, are answered by a one-cycle `byte_ack` pulse in the cycle after the byte. Any other device byte gets no acknowledge, and its transaction has no effect.
- R2: A single data byte of 8'h02 written to the status word address (8'h3F) sets `wel`.
- R3: A single status byte of 8'h06 sets `wel`. It sets `rwel` only if `wel` was already set before that write. `rwel` is never high while `wel` is low.
- R4: A single status byte of 8'h00 clears both latches. Any other status value, for example 8'h07, changes neither latch.
- R5: A legal protected write that ends with a stop while `rwel` is set produces a one-cycle `cmt_vld` pulse. The pulse carries the word address, the byte count, and the data (byte k at bits 8k+7:8k, unused bytes zero). The same write clears `rwel` and leaves `wel` set.
- R6: A legal protected write that ends with a stop while `rwel` is clear is acknowledged byte by byte but is discarded. No commit occurs and neither latch changes.
- R7: A write aborted by `bus_err`, or by a start that arrives in place of a stop, is discarded. No commit occurs and `rwel` stays set.
- R8: Only these lengths are legal: exactly eight bytes starting at the time area base 8'h30; one to five bytes starting inside the control area 8'h10 to 8'h14 and not running past 8'h14; exactly one byte at the status address. Any other length, and any other address, has no effect.
- R9: A commit to the control area raises `busy` in the same cycle as `cmt_vld`, with `cmt_nv` high. `busy` then stays high for exactly NV_CYCLES cycles. A commit to the time area leaves `busy` low. Any write that ends while `busy` is high is ignored, including status writes.
- R10: A read transaction placed between the two unlock steps leaves both latches unchanged.
- R11: After reset, `wel`, `rwel`, `busy`, `cmt_vld` and `byte_ack` are low, and a programming cycle that was in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start condition seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| bus_byte_vld | input | 1 | A full byte was received (one-cycle pulse) |
| bus_byte | input | 8 | Received byte, valid with bus_byte_vld |
| bus_err | input | 1 | Framing error in the current transaction |
| byte_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| wel | output | 1 | First-stage write-enable latch |
| rwel | output | 1 | Second-stage register-write latch |
| busy | output | 1 | Non-volatile programming cycle in progress |
| cmt_vld | output | 1 | Commit strobe, one cycle |
| cmt_nv | output | 1 | Commit targets the non-volatile control area |
| cmt_addr | output | 8 | Start word address of the commit |
| cmt_cnt | output | 4 | Number of bytes committed |
| cmt_data | output | 64 | Committed bytes, byte k at bits 8k+7:8k |

## Verification
A wrong value in either latch becomes visible on `wel` or `rwel` in the second cycle after the stop that should have changed it. If the damage is hidden there, it shows up at the next protected write, which either commits when it should have been discarded or is dropped when it should have committed. A wrong frame phase or byte count shows up as a missing or extra `byte_ack`, in the cycle after the byte concerned, or as a wrong `cmt_cnt` or `cmt_data` in the commit cycle. A faulty busy counter shows up as a `busy` window that is not NV_CYCLES long, or as a status write that takes effect during the window.

// File: rtl/regwr_pkg.sv
// Shared constants and types for the two-step register write-enable controller.
// Assumes an 8-bit device address byte whose LSB is the read/write flag.
package regwr_pkg;

    localparam logic [7:0] DEV_WR_ID   = 8'hDE;
    localparam logic [7:0] DEV_RD_ID   = DEV_WR_ID | 8'h01;

    localparam logic [7:0] ST_SET_WEL  = 8'h02;
    localparam logic [7:0] ST_SET_BOTH = 8'h06;
    localparam logic [7:0] ST_CLR_ALL  = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_WORD,
        PH_DATA,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_STAT,
        RG_TIME,
        RG_CTRL
    } region_t;

endpackage

// File: rtl/regwr_frame.sv
// Transaction framer: follows start/stop/byte/error events, matches the
// device byte, captures the word address and stages up to MAX_BYTES data
// bytes. At a clean stop after a write with data it pulses fr_done. A start or
// an error during a write pulses fr_abort instead. Assumes that at most one
// event arrives per cycle.
module regwr_frame
    import regwr_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int CW        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ev_start,
    input  logic                   ev_stop,
    input  logic                   ev_byte,
    input  logic [7:0]             ev_data,
    input  logic                   ev_err,
    output logic                   byte_ack,
    output logic                   fr_done,
    output logic                   fr_abort,
    output logic [7:0]             fr_addr,
    output logic [CW-1:0]          fr_cnt,
    output logic [8*MAX_BYTES-1:0] fr_data
);

    localparam logic [CW-1:0] MAXC = CW'(MAX_BYTES);

    phase_t                 phase;
    logic [7:0]             waddr;
    logic [CW-1:0]          cnt;
    logic [8*MAX_BYTES-1:0] stage;

    wire in_write = (phase == PH_WORD) || (phase == PH_DATA);

    // Phase tracking, byte staging and the done/abort/ack pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            waddr    <= '0;
            cnt      <= '0;
            stage    <= '0;
            byte_ack <= 1'b0;
            fr_done  <= 1'b0;
            fr_abort <= 1'b0;
        end else begin
            byte_ack <= 1'b0;
            fr_done  <= 1'b0;
            fr_abort <= 1'b0;
            if (ev_err) begin
                fr_abort <= in_write;
                phase    <= PH_SKIP;
            end else if (ev_start) begin
                fr_abort <= in_write;
                phase    <= PH_DEV;
                cnt      <= '0;
                stage    <= '0;
            end else if (ev_stop) begin
                fr_done  <= (phase == PH_DATA) && (cnt != '0);
                phase    <= PH_IDLE;
            end else if (ev_byte) begin
                case (phase)
                    PH_DEV: begin
                        if (ev_data == DEV_WR_ID) begin
                            phase    <= PH_WORD;
                            byte_ack <= 1'b1;
                        end else if (ev_data == DEV_RD_ID) begin
                            phase    <= PH_READ;
                            byte_ack <= 1'b1;
                        end else begin
                            phase    <= PH_SKIP;
                        end
                    end
                    PH_WORD: begin
                        waddr    <= ev_data;
                        phase    <= PH_DATA;
                        byte_ack <= 1'b1;
                    end
                    PH_DATA: begin
                        byte_ack <= 1'b1;
                        if (cnt < MAXC) begin
                            stage[8*int'(cnt) +: 8] <= ev_data;
                            cnt <= cnt + 1'b1;
                        end else if (cnt == MAXC) begin
                            cnt <= cnt + 1'b1;   // overflow marker, never legal
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign fr_addr = waddr;
    assign fr_cnt  = cnt;
    assign fr_data = stage;

    // A transaction ends in at most one way per cycle.
    p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fr_done, fr_abort}));

    // An acknowledge always answers a byte of the previous cycle.
    p_ack_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |-> $past(ev_byte));

endmodule

// File: rtl/regwr_busy.sv
// Programming-cycle timer: a load pulse holds busy high for NV_CYCLES cycles,
// standing in for the slow non-volatile write. Assumes that no load arrives
// while busy is high.
module regwr_busy #(
    parameter int NV_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int BW = $clog2(NV_CYCLES + 1);

    logic [BW-1:0] left;

    // Counts the remaining cycles of the programming window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= BW'(NV_CYCLES);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign busy = (left != '0);

    // A load always opens a window in the next cycle.
    p_load_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // The policy never starts a second cycle during a running one.
    p_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/regwr_policy.sv
// Write policy: classifies each finished write by region and length, runs the
// two-stage unlock latches and issues commits. Assumes the frame fields stay
// stable in the cycle in which fr_done is high.
module regwr_policy
    import regwr_pkg::*;
#(
    parameter int TIME_BASE = 8'h30,
    parameter int TIME_LEN  = 8,
    parameter int CTRL_BASE = 8'h10,
    parameter int CTRL_LEN  = 5,
    parameter int STAT_ADDR = 8'h3F,
    parameter int MAX_BYTES = 8,
    parameter int CW        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fr_done,
    input  logic [7:0]             fr_addr,
    input  logic [CW-1:0]          fr_cnt,
    input  logic [8*MAX_BYTES-1:0] fr_data,
    input  logic                   busy,
    output logic                   nv_load,
    output logic                   wel,
    output logic                   rwel,
    output logic                   cmt_vld,
    output logic                   cmt_nv,
    output logic [7:0]             cmt_addr,
    output logic [CW-1:0]          cmt_cnt,
    output logic [8*MAX_BYTES-1:0] cmt_data
);

    region_t    region;
    logic       legal;
    logic       accept;
    logic       do_cmt;
    logic [7:0] st_val;

    // Sorts the finished write into a region and checks its length.
    always_comb begin
        int a;
        int n;
        a      = int'(fr_addr);
        n      = int'(fr_cnt);
        region = RG_NONE;
        legal  = 1'b0;
        if (a == STAT_ADDR) begin
            region = RG_STAT;
            legal  = (n == 1);
        end else if (a >= TIME_BASE && a < TIME_BASE + TIME_LEN) begin
            region = RG_TIME;
            legal  = (a == TIME_BASE) && (n == TIME_LEN);
        end else if (a >= CTRL_BASE && a < CTRL_BASE + CTRL_LEN) begin
            region = RG_CTRL;
            legal  = (n >= 1) && (a - CTRL_BASE + n <= CTRL_LEN);
        end
    end

    assign st_val  = fr_data[7:0];
    assign accept  = fr_done && !busy && legal;
    assign do_cmt  = accept && rwel && (region == RG_TIME || region == RG_CTRL);
    assign nv_load = do_cmt && (region == RG_CTRL);

    // Latch updates and the commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            rwel     <= 1'b0;
            cmt_vld  <= 1'b0;
            cmt_nv   <= 1'b0;
            cmt_addr <= '0;
            cmt_cnt  <= '0;
            cmt_data <= '0;
        end else begin
            cmt_vld <= 1'b0;
            if (do_cmt) begin
                cmt_vld  <= 1'b1;
                cmt_nv   <= (region == RG_CTRL);
                cmt_addr <= fr_addr;
                cmt_cnt  <= fr_cnt;
                cmt_data <= fr_data;
                rwel     <= 1'b0;
            end else if (accept && region == RG_STAT) begin
                case (st_val)
                    ST_SET_WEL:  wel <= 1'b1;
                    ST_SET_BOTH: begin
                        wel  <= 1'b1;
                        rwel <= wel;
                    end
                    ST_CLR_ALL: begin
                        wel  <= 1'b0;
                        rwel <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // The second stage can never be set alone.
    p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);

    // A commit needs the unlock from the cycle before and consumes it.
    p_commit_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |-> $past(rwel) && !rwel);

    // Nothing commits out of a busy window.
    p_commit_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |-> !$past(busy));

    // A commit never carries an empty or oversized burst.
    p_commit_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |-> (cmt_cnt != '0) && (int'(cmt_cnt) <= MAX_BYTES));

endmodule

// File: rtl/regwr_guard.sv
// Top of the two-step register write-enable controller: framer, write policy
// and programming-cycle timer. Assumes the bus front end delivers one event
// per cycle as single-cycle pulses.
module regwr_guard #(
    parameter int TIME_BASE = 8'h30,
    parameter int TIME_LEN  = 8,
    parameter int CTRL_BASE = 8'h10,
    parameter int CTRL_LEN  = 5,
    parameter int STAT_ADDR = 8'h3F,
    parameter int NV_CYCLES = 200,
    localparam int MAX_BYTES = (TIME_LEN > CTRL_LEN) ? TIME_LEN : CTRL_LEN,
    localparam int CW        = $clog2(MAX_BYTES + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_start,
    input  logic                   bus_stop,
    input  logic                   bus_byte_vld,
    input  logic [7:0]             bus_byte,
    input  logic                   bus_err,
    output logic                   byte_ack,
    output logic                   wel,
    output logic                   rwel,
    output logic                   busy,
    output logic                   cmt_vld,
    output logic                   cmt_nv,
    output logic [7:0]             cmt_addr,
    output logic [CW-1:0]          cmt_cnt,
    output logic [8*MAX_BYTES-1:0] cmt_data
);

    logic                   fr_done;
    logic                   fr_abort;
    logic [7:0]             fr_addr;
    logic [CW-1:0]          fr_cnt;
    logic [8*MAX_BYTES-1:0] fr_data;
    logic                   nv_load;

    regwr_frame #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_start (bus_start),
        .ev_stop  (bus_stop),
        .ev_byte  (bus_byte_vld),
        .ev_data  (bus_byte),
        .ev_err   (bus_err),
        .byte_ack (byte_ack),
        .fr_done  (fr_done),
        .fr_abort (fr_abort),
        .fr_addr  (fr_addr),
        .fr_cnt   (fr_cnt),
        .fr_data  (fr_data)
    );

    regwr_policy #(
        .TIME_BASE (TIME_BASE),
        .TIME_LEN  (TIME_LEN),
        .CTRL_BASE (CTRL_BASE),
        .CTRL_LEN  (CTRL_LEN),
        .STAT_ADDR (STAT_ADDR),
        .MAX_BYTES (MAX_BYTES),
        .CW        (CW)
    ) u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .fr_done  (fr_done),
        .fr_addr  (fr_addr),
        .fr_cnt   (fr_cnt),
        .fr_data  (fr_data),
        .busy     (busy),
        .nv_load  (nv_load),
        .wel      (wel),
        .rwel     (rwel),
        .cmt_vld  (cmt_vld),
        .cmt_nv   (cmt_nv),
        .cmt_addr (cmt_addr),
        .cmt_cnt  (cmt_cnt),
        .cmt_data (cmt_data)
    );

    regwr_busy #(.NV_CYCLES(NV_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (nv_load),
        .busy  (busy)
    );

    // An aborted write never commits in the following cycle.
    p_abort_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_abort |=> !cmt_vld);

    // Commits only follow a clean end of transaction.
    p_commit_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |-> $past(fr_done));

endmodule

// File: tb/regwr_guard_test.sv
// Self-checking bench: a transaction vector table walked by one loop, then
// directed tests for the busy window and reset.
module regwr_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVC        = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        bus_byte_vld = 1'b0;
    logic [7:0]  bus_byte = '0;
    logic        bus_err = 1'b0;
    logic        byte_ack, wel, rwel, busy, cmt_vld, cmt_nv;
    logic [7:0]  cmt_addr;
    logic [3:0]  cmt_cnt;
    logic [63:0] cmt_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwr_guard #(.NV_CYCLES(NVC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .bus_err(bus_err),
        .byte_ack(byte_ack), .wel(wel), .rwel(rwel), .busy(busy),
        .cmt_vld(cmt_vld), .cmt_nv(cmt_nv), .cmt_addr(cmt_addr),
        .cmt_cnt(cmt_cnt), .cmt_data(cmt_data)
    );

    // fin: 0 = stop, 1 = framing error then stop, 2 = start then stop
    typedef struct packed {
        logic [7:0]  dev;
        logic [7:0]  wa;
        logic [3:0]  n;
        logic [63:0] d;
        logic [1:0]  fin;
        logic        ew;
        logic        er;
        logic        ec;
        logic        env;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{8'hDE, 8'h3F, 4'd1, 64'h02, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{8'hDE, 8'h30, 4'd8, 64'h1111_2222_3333_4444, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
        '{8'hDE, 8'h3F, 4'd1, 64'h06, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{8'hDF, 8'h00, 4'd0, 64'h00, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{8'hA0, 8'h3F, 4'd1, 64'h00, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
        '{8'hDE, 8'h3F, 4'd1, 64'h07, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{8'hDE, 8'h30, 4'd7, 64'h0077_6655_4433_2211, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8}, // R8
        '{8'hDE, 8'h13, 4'd3, 64'h00_3C2B1A, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{8'hDE, 8'h20, 4'd1, 64'h55, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{8'hDE, 8'h10, 4'd2, 64'hBEEF, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7}, // R7
        '{8'hDE, 8'h12, 4'd3, 64'h00_CAFE01, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7}, // R7
        '{8'hDE, 8'h11, 4'd3, 64'h00_C3B2A1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5}, // R5, R9
        '{8'hDE, 8'h3F, 4'd1, 64'h02, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{8'hDE, 8'h3F, 4'd1, 64'h06, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{8'hDE, 8'h30, 4'd8, 64'h0807_0605_0403_0201, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5
        '{8'hDE, 8'h3F, 4'd1, 64'h06, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{8'hDE, 8'h3F, 4'd1, 64'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{8'hDE, 8'h3F, 4'd1, 64'h06, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{8'hDE, 8'h3F, 4'd2, 64'h0006, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8} // R8
    };

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        @(negedge clk);
        bus_byte = b;
        bus_byte_vld = 1'b1;
        @(negedge clk);
        bus_byte_vld = 1'b0;
        ack = byte_ack;
    endtask

    // Ends at the negedge in which a commit strobe would be visible.
    task automatic run_txn(input logic [7:0] dev, input logic [7:0] wa, input int n,
                           input logic [63:0] d, input logic [1:0] fin, output logic ack_dev);
        logic junk;
        pulse_start();
        send_byte(dev, ack_dev);
        if (dev != 8'hDF) begin
            send_byte(wa, junk);
            for (int i = 0; i < n; i++) send_byte(d[8*i +: 8], junk);
        end
        if (fin == 2'd1) begin
            @(negedge clk) bus_err = 1'b1;
            @(negedge clk) bus_err = 1'b0;
        end else if (fin == 2'd2) begin
            pulse_start();
        end
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        logic ack;
        logic [63:0] mask;
        int span;
        repeat (3) @(negedge clk);
        check("R11 wel after reset", 64'(wel), 64'd0);
        check("R11 rwel after reset", 64'(rwel), 64'd0);
        check("R11 busy after reset", 64'(busy), 64'd0);
        check("R11 cmt_vld after reset", 64'(cmt_vld), 64'd0);
        check("R11 byte_ack after reset", 64'(byte_ack), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            string tag;
            t = VECS[v];
            tag = $sformatf("R%0d vec %0d", t.req, v);
            wait_idle();
            run_txn(t.dev, t.wa, int'(t.n), t.d, t.fin, ack);
            check({tag, " wel"}, 64'(wel), 64'(t.ew));
            check({tag, " rwel"}, 64'(rwel), 64'(t.er));
            check({tag, " cmt_vld"}, 64'(cmt_vld), 64'(t.ec));
            check({tag, " device ack (R1)"}, 64'(ack),
                  64'((t.dev == 8'hDE) || (t.dev == 8'hDF)));
            if (t.ec) begin
                mask = (t.n >= 4'd8) ? '1 : ((64'd1 << (8*int'(t.n))) - 64'd1);
                check({tag, " cmt_addr"}, 64'(cmt_addr), 64'(t.wa));
                check({tag, " cmt_cnt"}, 64'(cmt_cnt), 64'(t.n));
                check({tag, " cmt_data"}, cmt_data, t.d & mask);
                check({tag, " cmt_nv (R9)"}, 64'(cmt_nv), 64'(t.env));
                check({tag, " busy (R9)"}, 64'(busy), 64'(t.env));
            end
        end

        // R9: busy window length after a control commit
        wait_idle();
        run_txn(8'hDE, 8'h3F, 1, 64'h06, 2'd0, ack);
        run_txn(8'hDE, 8'h10, 1, 64'h5A, 2'd0, ack);
        check("R9 control commit", 64'(cmt_vld), 64'd1);
        span = 0;
        while (busy && span < 10*NVC) begin
            span++;
            @(negedge clk);
        end
        check("R9 busy span", 64'(span), 64'(NVC));

        // R9: status write during busy is ignored; then R11 reset drops it
        run_txn(8'hDE, 8'h3F, 1, 64'h06, 2'd0, ack);
        run_txn(8'hDE, 8'h10, 5, 64'h00_5544332211, 2'd0, ack);
        check("R5 five-byte control commit", 64'(cmt_cnt), 64'd5);
        run_txn(8'hDE, 8'h3F, 1, 64'h00, 2'd0, ack);
        check("R9 busy still high", 64'(busy), 64'd1);
        check("R9 status clear ignored while busy", 64'(wel), 64'd1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 busy dropped by reset", 64'(busy), 64'd0);
        check("R11 wel cleared by reset", 64'(wel), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(8'hDE, 8'h3F, 1, 64'h06, 2'd0, ack);
        check("R3 06 after reset sets only wel", 64'({wel, rwel}), 64'b10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule